// File: doc/BRIEF.md
# Transposing Burst Address Sequencer for External Memory

This block produces the command stream that an external memory controller needs to turn a row-ordered stream of bursts into a column-ordered one. Bursts arriving on the input handshake are written to consecutive burst addresses of one half of a two-region buffer. Once a full block is stored there, the sequencer reads it back column by column. The writer fills the other region in the meantime, and write and read commands are interleaved in short turns of fixed length.

Each command carries a burst address, a write/read flag and a fixed burst length. The command is accepted when the memory ready input is high. The memory and the data it holds sit outside this block, and so does any reordering inside a burst. The read-data valid strobe coming back from the memory is passed on to the output side. A synchronous restart input, used when the surrounding logic detects a broken sync period, drops all progress and starts over with the first write.

Top module: `reorder_seq_top`

## Requirements
- R1: After reset or a one-cycle `restart` pulse, the sequencer is in a write turn, nothing is readable, and the next command address is 0 (region 0, index 0). While `restart` is high, no command is valid and `inReady` is low.
- R2: `cmdAddr` is {region bit (MSB), burst index (lower bits)}. Accepted writes take the indices 0 to BLOCK-1 in order. The region bit is the parity of the block count since the last restart.
- R3: A command is accepted only in a cycle where `cmdValid` and `memReady` are both high. While an offered command waits on `memReady` and the turn does not change, its address is held.
- R4: Within a block, the k-th accepted read (k from 0) uses burst index (k*BURSTS_PER_ROW) mod (BLOCK-1) for k < BLOCK-1, and index BLOCK-1 for the last read. This is a stride of one row through the block, which moves to the next column on wrap.
- R5: Reads address only the region of a completely written block, never the region being filled. The first command run after restart is exactly BLOCK writes.
- R6: While the input offers data continuously, every run of commands after the first holds at most WR_PER_TURN writes or RD_PER_TURN reads.
- R7: `inReady` is high only in a cycle where a write command is being accepted. Each input handshake is exactly one accepted write.
- R8: `outValid` equals `rdValidIn` of the previous cycle, and it is 0 in the cycle after a restart.
- R9: `cmdBurstLen` always reads BURST_LEN (16 in the default build).
- R10: A write turn with no input offered yields to reads, so the last stored block is drained after the input stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart after a sync-period fault |
| inValid | input | 1 | A burst of input data is ready to be written |
| inReady | output | 1 | Input burst taken (write command accepted) |
| cmdValid | output | 1 | Memory command valid |
| memReady | input | 1 | Memory accepts the command |
| cmdWrite | output | 1 | 1 = write command, 0 = read command |
| cmdAddr | output | 6 | Burst address {region, index} |
| cmdBurstLen | output | 5 | Samples per burst |
| rdValidIn | input | 1 | Read data valid from the memory |
| outValid | output | 1 | Read data valid toward the output |

## Verification
The bench builds the block with bursts of 16 samples, 8 bursts per row, 4 rows and turns of 4 commands. These values give a 32-burst block, so several block swaps, both region parities and the wrap of the column stride occur within a few hundred cycles. Because the write and read turns are the same length, the steady state alternates exactly, which makes the run-length rule checkable. Random ready stalls and input gaps show that addresses are held, and a restart in the middle of a block tests the return to the initial state.

// File: rtl/reorder_seq_pkg.sv
package reorder_seq_pkg;
  typedef enum logic {
    PH_WRITE = 1'b0,
    PH_READ  = 1'b1
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrAccept;
    logic rdAccept;
    logic clear;
    logic selRead;
  } seq_strobe_t;
endpackage

// File: rtl/reorder_seq_ctrl.sv
module reorder_seq_ctrl
  import reorder_seq_pkg::*;
#(
  parameter int WR_PER_TURN = 4,
  parameter int RD_PER_TURN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        restart,
  input  logic        inValid,
  input  logic        memReady,
  input  logic        wrLast,
  input  logic        rdLast,
  output logic        cmdValid,
  output logic        inReady,
  output seq_strobe_t strobe
);
  localparam int TURN_MAX = (WR_PER_TURN > RD_PER_TURN) ? WR_PER_TURN : RD_PER_TURN;
  localparam int TURN_W   = (TURN_MAX > 1) ? $clog2(TURN_MAX) : 1;

  phase_t phase, phaseNext;
  logic [TURN_W-1:0] turnCnt, turnNext;
  logic readable, readableNext;
  logic writeAllowed, accept, wrAcc, rdAcc, wrTurnEnd, rdTurnEnd;

  always_comb begin
    // the last write of a block must wait while the other region is unread
    writeAllowed = !(wrLast && readable);
    if (phase == PH_WRITE) cmdValid = !restart && inValid && writeAllowed;
    else                   cmdValid = !restart && readable;
    accept    = cmdValid && memReady;
    wrAcc     = accept && (phase == PH_WRITE);
    rdAcc     = accept && (phase == PH_READ);
    inReady   = wrAcc;
    wrTurnEnd = (turnCnt == TURN_W'(WR_PER_TURN - 1));
    rdTurnEnd = (turnCnt == TURN_W'(RD_PER_TURN - 1));

    readableNext = readable;
    if (wrAcc && wrLast) readableNext = 1'b1;
    if (rdAcc && rdLast) readableNext = 1'b0;

    phaseNext = phase;
    turnNext  = turnCnt;
    if (phase == PH_WRITE) begin
      if (wrAcc) begin
        if (wrTurnEnd) begin
          turnNext  = '0;
          phaseNext = readableNext ? PH_READ : PH_WRITE;
        end else begin
          turnNext = turnCnt + 1'b1;
        end
      end else if (!writeAllowed || (!inValid && readable)) begin
        turnNext  = '0;
        phaseNext = PH_READ;
      end
    end else begin
      if (rdAcc) begin
        if (rdTurnEnd || rdLast) begin
          turnNext  = '0;
          phaseNext = PH_WRITE;
        end else begin
          turnNext = turnCnt + 1'b1;
        end
      end else if (!readable) begin
        turnNext  = '0;
        phaseNext = PH_WRITE;
      end
    end

    strobe.wrAccept = wrAcc;
    strobe.rdAccept = rdAcc;
    strobe.clear    = restart;
    strobe.selRead  = (phase == PH_READ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_WRITE;
      turnCnt  <= '0;
      readable <= 1'b0;
    end else if (restart) begin
      phase    <= PH_WRITE;
      turnCnt  <= '0;
      readable <= 1'b0;
    end else begin
      phase    <= phaseNext;
      turnCnt  <= turnNext;
      readable <= readableNext;
    end
  end
endmodule

// File: rtl/reorder_seq_dpath.sv
module reorder_seq_dpath
  import reorder_seq_pkg::*;
#(
  parameter int BURSTS_PER_ROW = 8,
  parameter int ROWS           = 4,
  parameter bit OUT_REG        = 1'b1,
  localparam int BLOCK  = BURSTS_PER_ROW * ROWS,
  localparam int IDX_W  = (BLOCK > 1) ? $clog2(BLOCK) : 1,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic              rdValidIn,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              wrLast,
  output logic              rdLast,
  output logic              wrRegion,
  output logic              outValid
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = (BURSTS_PER_ROW > 1) ? $clog2(BURSTS_PER_ROW) : 1;

  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [ROW_W-1:0] rdRow;
  logic [COL_W-1:0] rdCol;
  logic rowWrap, colWrap;

  always_comb begin
    rowWrap = (rdRow == ROW_W'(ROWS - 1));
    colWrap = (rdCol == COL_W'(BURSTS_PER_ROW - 1));
    wrLast  = (wrIdx == IDX_W'(BLOCK - 1));
    rdLast  = rowWrap && colWrap;
    rdIdx   = IDX_W'(rdRow) * IDX_W'(BURSTS_PER_ROW) + IDX_W'(rdCol);
    cmdAddr = strobe.selRead ? {~wrRegion, rdIdx} : {wrRegion, wrIdx};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx    <= '0;
      wrRegion <= 1'b0;
      rdRow    <= '0;
      rdCol    <= '0;
    end else if (strobe.clear) begin
      wrIdx    <= '0;
      wrRegion <= 1'b0;
      rdRow    <= '0;
      rdCol    <= '0;
    end else begin
      if (strobe.wrAccept) begin
        wrIdx <= wrLast ? '0 : wrIdx + 1'b1;
        if (wrLast) wrRegion <= ~wrRegion;
      end
      if (strobe.rdAccept) begin
        if (rowWrap) begin
          rdRow <= '0;
          rdCol <= colWrap ? '0 : rdCol + 1'b1;
        end else begin
          rdRow <= rdRow + 1'b1;
        end
      end
    end
  end

  generate
    if (OUT_REG) begin : g_outReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             outValid <= 1'b0;
        else if (strobe.clear) outValid <= 1'b0;
        else                   outValid <= rdValidIn;
      end
    end else begin : g_outComb
      assign outValid = rdValidIn && !strobe.clear;
    end
  endgenerate
endmodule

// File: rtl/reorder_seq_top.sv
module reorder_seq_top
  import reorder_seq_pkg::*;
#(
  parameter int BURST_LEN      = 16,
  parameter int BURSTS_PER_ROW = 8,
  parameter int ROWS           = 4,
  parameter int WR_PER_TURN    = 4,
  parameter int RD_PER_TURN    = 4,
  parameter bit OUT_REG        = 1'b1,
  localparam int BLOCK  = BURSTS_PER_ROW * ROWS,
  localparam int IDX_W  = (BLOCK > 1) ? $clog2(BLOCK) : 1,
  localparam int ADDR_W = IDX_W + 1,
  localparam int LEN_W  = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic              inValid,
  output logic              inReady,
  output logic              cmdValid,
  input  logic              memReady,
  output logic              cmdWrite,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [LEN_W-1:0]  cmdBurstLen,
  input  logic              rdValidIn,
  output logic              outValid
);
  seq_strobe_t strobe;
  logic wrLast, rdLast, wrRegion;

  reorder_seq_ctrl #(
    .WR_PER_TURN(WR_PER_TURN),
    .RD_PER_TURN(RD_PER_TURN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .restart(restart), .inValid(inValid),
    .memReady(memReady), .wrLast(wrLast), .rdLast(rdLast),
    .cmdValid(cmdValid), .inReady(inReady), .strobe(strobe)
  );

  reorder_seq_dpath #(
    .BURSTS_PER_ROW(BURSTS_PER_ROW),
    .ROWS(ROWS),
    .OUT_REG(OUT_REG)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdValidIn(rdValidIn),
    .cmdAddr(cmdAddr), .wrLast(wrLast), .rdLast(rdLast),
    .wrRegion(wrRegion), .outValid(outValid)
  );

  assign cmdWrite    = !strobe.selRead;
  assign cmdBurstLen = LEN_W'(BURST_LEN);
endmodule

// File: rtl/reorder_seq_chk.sv
module reorder_seq_chk #(
  parameter int ADDR_W  = 6,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              restart,
  input logic              inReady,
  input logic              cmdValid,
  input logic              memReady,
  input logic              cmdWrite,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic              rdValidIn,
  input logic              outValid,
  input logic              wrRegion
);
  a_r1_restart_state: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (cmdWrite && (cmdAddr == '0)));

  a_r1_restart_quiet: assert property (@(posedge clk) disable iff (!rstN)
    restart |-> (!cmdValid && !inReady));

  a_r3_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !(cmdValid && memReady) && !restart) |=> (!cmdWrite || $stable(cmdAddr)));

  a_r3_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWrite && cmdValid && !memReady && !restart) |=> (!cmdWrite && $stable(cmdAddr)));

  a_r5_read_region: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdWrite) |-> (cmdAddr[ADDR_W-1] != wrRegion));

  a_r7_in_ready: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (cmdValid && cmdWrite && memReady));

  generate
    if (OUT_REG) begin : g_outChk
      a_r8_out_valid: assert property (@(posedge clk) disable iff (!rstN)
        !restart |=> (outValid == $past(rdValidIn)));
    end
  endgenerate
endmodule

bind reorder_seq_top reorder_seq_chk #(
  .ADDR_W(ADDR_W),
  .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rstN(rstN), .restart(restart), .inReady(inReady),
  .cmdValid(cmdValid), .memReady(memReady), .cmdWrite(cmdWrite),
  .cmdAddr(cmdAddr), .rdValidIn(rdValidIn), .outValid(outValid),
  .wrRegion(wrRegion)
);

// File: tb/sim_reorder_seq_top.sv
module sim_reorder_seq_top;
  localparam int BL = 16, BPR = 8, ROWS = 4, WT = 4, RT = 4;
  localparam int BLOCK = BPR * ROWS;
  localparam int ADDR_W = 6;

  logic clk = 1'b0, rstN = 1'b0, restart = 1'b0;
  logic inValid = 1'b0, memReady = 1'b0, rdValidIn = 1'b0;
  logic inReady, cmdValid, cmdWrite, outValid;
  logic [ADDR_W-1:0] cmdAddr;
  logic [4:0] cmdBurstLen;

  int checks = 0, errors = 0;
  int expWr[$], expRd[$];
  bit monOn = 0, contStream = 0, randReady = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  reorder_seq_top #(
    .BURST_LEN(BL), .BURSTS_PER_ROW(BPR), .ROWS(ROWS),
    .WR_PER_TURN(WT), .RD_PER_TURN(RT), .OUT_REG(1'b1)
  ) u0 (
    .clk(clk), .rstN(rstN), .restart(restart), .inValid(inValid),
    .inReady(inReady), .cmdValid(cmdValid), .memReady(memReady),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdBurstLen(cmdBurstLen),
    .rdValidIn(rdValidIn), .outValid(outValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected addresses computed from the requirement formulas
  task automatic pushBlocks(input int n);
    for (int b = 0; b < n; b++) begin
      for (int i = 0; i < BLOCK; i++) expWr.push_back(((b % 2) << 5) | i);
      for (int k = 0; k < BLOCK; k++) begin
        int idx;
        idx = (k == BLOCK - 1) ? BLOCK - 1 : (k * BPR) % (BLOCK - 1);
        expRd.push_back(((b % 2) << 5) | idx);
      end
    end
  endtask

  // scoreboard monitor
  int runLen = 0, runIdx = 0, heldAddr = 0;
  bit lastKind = 0, holdPending = 0, heldKind = 0, prevRdv = 0, prevOk = 0, afterRestart = 0;
  always @(negedge clk) begin
    if (rstN && monOn) begin
      if (restart) begin
        runLen = 0; runIdx = 0; holdPending = 0; prevOk = 0; afterRestart = 1;
        check(!cmdValid && !inReady, "R1 quiet during restart", cmdValid, 0);
      end else begin
        if (afterRestart) check(outValid == 1'b0, "R8 cleared after restart", outValid, 0);
        else if (prevOk) check(outValid == prevRdv, "R8 delay", outValid, prevRdv);
        afterRestart = 0;
        prevRdv = rdValidIn; prevOk = 1;
        if (holdPending && cmdValid && (cmdWrite == heldKind))
          check(cmdAddr == heldAddr, "R3 hold", cmdAddr, heldAddr);
        holdPending = 0;
        if (inValid && inReady)
          check(cmdValid && memReady && cmdWrite, "R7 handshake", {cmdValid, memReady, cmdWrite}, 7);
        if (cmdValid && !memReady) begin
          holdPending = 1; heldAddr = cmdAddr; heldKind = cmdWrite;
        end
        if (cmdValid && memReady) begin
          if (cmdWrite) begin
            if (expWr.size() == 0) check(0, "R2 unexpected write", cmdAddr, -1);
            else begin
              int e; e = expWr.pop_front();
              check(cmdAddr == e, "R2 write address", cmdAddr, e);
            end
          end else begin
            if (expRd.size() == 0) check(0, "R4 unexpected read", cmdAddr, -1);
            else begin
              int e; e = expRd.pop_front();
              check(cmdAddr == e, "R4 R5 read address", cmdAddr, e);
            end
          end
          if (runLen > 0 && cmdWrite != lastKind) begin
            if (runIdx == 0)
              check(lastKind && runLen == BLOCK, "R5 first run", runLen, BLOCK);
            else if (contStream)
              check(runLen <= (lastKind ? WT : RT), "R6 turn length", runLen, lastKind ? WT : RT);
            runIdx++;
            runLen = 1;
          end else runLen++;
          lastKind = cmdWrite;
        end
      end
    end
  end

  // memory side stimulus
  initial begin
    forever begin
      @(posedge clk); #1;
      memReady  = randReady ? ($urandom_range(0, 3) != 0) : 1'b1;
      rdValidIn = $urandom_range(0, 1);
    end
  end

  task automatic doRestart();
    @(posedge clk); #1;
    restart = 1'b1;
    expWr.delete(); expRd.delete();
    @(posedge clk); #1;
    restart = 1'b0;
  endtask

  task automatic feed(input int total, input bit gaps, input int restartAt);
    int sent = 0;
    int rAt = restartAt;
    while (sent < total) begin
      @(negedge clk);
      if (inValid && inReady && !restart) sent++;
      @(posedge clk); #1;
      restart = 1'b0;
      if (rAt >= 0 && sent == rAt) begin
        restart = 1'b1;
        expWr.delete(); expRd.delete();
        pushBlocks(total / BLOCK);
        sent = 0; rAt = -1;
      end
      inValid = (sent < total) && (!gaps || $urandom_range(0, 3) != 0);
    end
    inValid = 1'b0;
    restart = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((expWr.size() != 0 || expRd.size() != 0) && n < 2000) begin
      @(negedge clk); n++;
    end
    check(expWr.size() == 0 && expRd.size() == 0, tag, expWr.size() + expRd.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1, R9: reset state
    check(cmdValid == 1'b0, "R1 no command after reset", cmdValid, 0);
    check(inReady == 1'b0, "R1 inReady low after reset", inReady, 0);
    check(cmdWrite == 1'b1, "R1 write turn after reset", cmdWrite, 1);
    check(cmdAddr == 0, "R1 address after reset", cmdAddr, 0);
    check(outValid == 1'b0, "R8 outValid after reset", outValid, 0);
    check(cmdBurstLen == BL, "R9 burst length", cmdBurstLen, BL);
    monOn = 1;

    // continuous input, memory always ready: exact alternation
    contStream = 1; randReady = 0;
    pushBlocks(3);
    feed(3 * BLOCK, 1'b0, -1);
    drain("R10 last block drained (continuous)");
    contStream = 0;

    // restart returns to initial state
    doRestart();
    @(negedge clk);
    check(cmdWrite == 1'b1 && cmdAddr == 0, "R1 state after restart", cmdAddr, 0);

    // random ready stalls and input gaps
    randReady = 1;
    pushBlocks(2);
    feed(2 * BLOCK, 1'b1, -1);
    drain("R10 drained with stalls");

    // restart in the middle of the first block
    doRestart();
    pushBlocks(2);
    feed(2 * BLOCK, 1'b1, 20);
    drain("R1 R10 drained after mid-block restart");
    check(cmdBurstLen == BL, "R9 burst length at end", cmdBurstLen, BL);

    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule